// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node controller for a shared-memory multiprocessor that has no broadcast bus. For each memory block it owns, it keeps a coherence state and a vector with one bit per processor showing which caches hold a copy. It also holds the data of those blocks. Caches send it read misses, write misses and write-backs. The controller answers each request point to point. It sends invalidations, fetches and fetch-invalidations only to the caches that the directory names. After that it sends the data reply to the requester.

The controller serves one request at a time. After it accepts a miss, it keeps its input ready low until every outgoing message for that miss has been taken. The one exception is the write-back it is waiting for from an exclusive owner, which it accepts. The output channel follows a valid/ready handshake. A message waiting on the output does not change until it is accepted.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty sharer vector and zero data, in_ready is high and out_valid is low.
- R2: Message kind codes on both channels are 0 read miss, 1 write miss, 2 invalidate, 3 fetch, 4 fetch-invalidate, 5 data reply, 6 write-back. Every outgoing message carries the request's block address. Only a data reply carries nonzero data.
- R3: A read miss to an Uncached or Shared block returns the stored data to the requester. The block becomes Shared with the requester added to its sharers.
- R4: A write miss to an Uncached block returns the stored data. The block becomes Exclusive with the requester as its only sharer.
- R5: A write miss to a Shared block sends one invalidate to each sharer other than the requester, in ascending processor index. It then returns the data, and the block becomes Exclusive with the requester alone.
- R6: A read miss to an Exclusive block sends a fetch to the owner and waits for the owner's write-back of that address. It stores the written-back data and replies with it. The block becomes Shared with the owner and the requester as sharers.
- R7: A write miss to an Exclusive block sends a fetch-invalidate to the owner. It stores the written-back data and replies with it. The requester becomes the sole owner.
- R8: A write-back from the owner of an Exclusive block updates the stored data and leaves the block Uncached with no sharers. No outgoing message is produced.
- R9: A write-back from a processor that does not own the block, and any incoming invalidate, fetch, fetch-invalidate or data reply, is accepted and changes neither data nor directory.
- R10: While a request is in progress, in_ready stays low except for the awaited write-back. A pending outgoing message holds all its fields while out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming message present |
| in_ready | output | 1 | Incoming message accepted this cycle |
| in_kind | input | 3 | Incoming message kind |
| in_proc | input | 2 | Sending processor index |
| in_addr | input | 4 | Block address |
| in_data | input | 16 | Write-back data |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Network takes the outgoing message |
| out_kind | output | 3 | Outgoing message kind |
| out_proc | output | 2 | Destination processor index |
| out_addr | output | 4 | Block address |
| out_data | output | 16 | Reply data |

## Verification
The hardest case to reach from the ports is an Exclusive block, because it needs an earlier write miss to create the owner. After that, the bench must take the part of the owning cache: it supplies the write-back while the controller is stalled waiting for it. The stimulus walks one block through Uncached, Shared with two sharers, Exclusive, a fetch back to Shared, an upgrade from a sharer, and a fetch-invalidate. A reference model in the bench predicts every outgoing message and the data returned. Some of these steps run with out_ready toggling, so that held messages and invalidate order are checked under backpressure. Write-backs from non-owners are followed by a read whose reply shows that memory kept its old value.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    MSG_RD_MISS   = 3'd0,
    MSG_WR_MISS   = 3'd1,
    MSG_INVAL     = 3'd2,
    MSG_FETCH     = 3'd3,
    MSG_FETCH_INV = 3'd4,
    MSG_DATA      = 3'd5,
    MSG_WBACK     = 3'd6
  } msg_kind_e;

  typedef enum logic [1:0] {
    BLK_UNCACHED = 2'd0,
    BLK_SHARED   = 2'd1,
    BLK_EXCL     = 2'd2
  } blk_state_e;

  typedef enum logic [2:0] {
    ENG_IDLE   = 3'd0,
    ENG_EXEC   = 3'd1,
    ENG_INVAL  = 3'd2,
    ENG_FETCH  = 3'd3,
    ENG_WAITWB = 3'd4,
    ENG_REPLY  = 3'd5
  } eng_state_e;
endpackage

// File: rtl/dir_pick.sv
module dir_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins, giving ascending service order
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int NBLK  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output blk_state_e        rd_state,
  output logic [NPROC-1:0]  rd_sharers,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dir_we,
  input  blk_state_e        wr_state,
  input  logic [NPROC-1:0]  wr_sharers,
  input  logic              mem_we,
  input  logic [DATA_W-1:0] wr_data
);
  blk_state_e        state_q [NBLK];
  logic [NPROC-1:0]  share_q [NBLK];
  logic [DATA_W-1:0] mem_q   [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        state_q[b] <= BLK_UNCACHED;
        share_q[b] <= '0;
        mem_q[b]   <= '0;
      end
    end else begin
      if (dir_we) begin
        state_q[addr] <= wr_state;
        share_q[addr] <= wr_sharers;
      end
      if (mem_we) mem_q[addr] <= wr_data;
    end
  end

  assign rd_state   = state_q[addr];
  assign rd_sharers = share_q[addr];
  assign rd_data    = mem_q[addr];

  for (genvar b = 0; b < NBLK; b++) begin : g_chk
    assert_excl_one_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state_q[b] == BLK_EXCL |-> $countones(share_q[b]) == 1);
    assert_uncached_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state_q[b] == BLK_UNCACHED |-> share_q[b] == '0);
    assert_shared_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q[b] == BLK_SHARED |-> share_q[b] != '0);
  end
endmodule

// File: rtl/dir_engine.sv
module dir_engine
  import dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [PW-1:0]     in_proc,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [PW-1:0]     out_proc,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W-1:0] addr_q,
  input  blk_state_e        rd_state,
  input  logic [NPROC-1:0]  rd_sharers,
  input  logic [DATA_W-1:0] rd_data,
  output logic [NPROC-1:0]  pend_q,
  input  logic [PW-1:0]     pend_idx,
  input  logic [PW-1:0]     owner_idx,
  output logic              dir_we,
  output blk_state_e        wr_state,
  output logic [NPROC-1:0]  wr_sharers,
  output logic              mem_we,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [NPROC-1:0] ONE = NPROC'(1);

  eng_state_e        st_q, st_d;
  msg_kind_e         kind_q;
  logic [PW-1:0]     src_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_en, pend_en;
  logic [NPROC-1:0]  pend_d, src_oh, pend_left;
  logic              wb_match;

  assign src_oh    = ONE << src_q;
  assign pend_left = pend_q & ~(ONE << pend_idx);
  assign wb_match  = in_valid && (in_kind == MSG_WBACK) &&
                     (in_proc == owner_idx) && (in_addr == addr_q);

  // next-state and output decode
  always_comb begin
    st_d       = st_q;
    cap_en     = 1'b0;
    pend_en    = 1'b0;
    pend_d     = pend_q;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    out_kind   = MSG_DATA;
    out_proc   = src_q;
    out_addr   = addr_q;
    out_data   = '0;
    dir_we     = 1'b0;
    wr_state   = rd_state;
    wr_sharers = rd_sharers;
    mem_we     = 1'b0;
    wr_data    = data_q;
    unique case (st_q)
      ENG_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          cap_en = 1'b1;
          st_d   = ENG_EXEC;
        end
      end
      ENG_EXEC: begin
        st_d = ENG_IDLE;
        unique case (kind_q)
          MSG_RD_MISS: begin
            if (rd_state == BLK_EXCL) begin
              st_d = ENG_FETCH;
            end else begin
              dir_we     = 1'b1;
              wr_state   = BLK_SHARED;
              wr_sharers = ((rd_state == BLK_UNCACHED) ? '0 : rd_sharers) | src_oh;
              st_d       = ENG_REPLY;
            end
          end
          MSG_WR_MISS: begin
            if (rd_state == BLK_EXCL) begin
              st_d = ENG_FETCH;
            end else begin
              pend_en = 1'b1;
              pend_d  = (rd_state == BLK_SHARED) ? (rd_sharers & ~src_oh) : '0;
              if (pend_d == '0) begin
                dir_we     = 1'b1;
                wr_state   = BLK_EXCL;
                wr_sharers = src_oh;
                st_d       = ENG_REPLY;
              end else begin
                st_d = ENG_INVAL;
              end
            end
          end
          MSG_WBACK: begin
            if (rd_state == BLK_EXCL && rd_sharers[src_q]) begin
              mem_we     = 1'b1;
              dir_we     = 1'b1;
              wr_state   = BLK_UNCACHED;
              wr_sharers = '0;
            end
          end
          default: st_d = ENG_IDLE;
        endcase
      end
      ENG_INVAL: begin
        out_valid = 1'b1;
        out_kind  = MSG_INVAL;
        out_proc  = pend_idx;
        if (out_ready) begin
          pend_en = 1'b1;
          pend_d  = pend_left;
          if (pend_left == '0) begin
            dir_we     = 1'b1;
            wr_state   = BLK_EXCL;
            wr_sharers = src_oh;
            st_d       = ENG_REPLY;
          end
        end
      end
      ENG_FETCH: begin
        out_valid = 1'b1;
        out_kind  = (kind_q == MSG_WR_MISS) ? MSG_FETCH_INV : MSG_FETCH;
        out_proc  = owner_idx;
        if (out_ready) st_d = ENG_WAITWB;
      end
      ENG_WAITWB: begin
        in_ready = wb_match;
        if (wb_match) begin
          mem_we  = 1'b1;
          wr_data = in_data;
          dir_we  = 1'b1;
          if (kind_q == MSG_RD_MISS) begin
            wr_state   = BLK_SHARED;
            wr_sharers = rd_sharers | src_oh;
          end else begin
            wr_state   = BLK_EXCL;
            wr_sharers = src_oh;
          end
          st_d = ENG_REPLY;
        end
      end
      ENG_REPLY: begin
        out_valid = 1'b1;
        out_kind  = MSG_DATA;
        out_data  = rd_data;
        if (out_ready) st_d = ENG_IDLE;
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      kind_q <= MSG_RD_MISS;
      src_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      pend_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        kind_q <= msg_kind_e'(in_kind);
        src_q  <= in_proc;
        addr_q <= in_addr;
        data_q <= in_data;
      end
      if (pend_en) pend_q <= pend_d;
    end
  end

  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_kind, out_proc, out_addr, out_data}));
  assert_busy_only_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ENG_IDLE) && in_ready |-> (in_kind == MSG_WBACK) && (in_addr == addr_q));
  assert_inval_not_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_kind == MSG_INVAL) |-> out_proc != src_q);
  assert_read_reply_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_REPLY) && (kind_q == MSG_RD_MISS) |->
      (rd_state == BLK_SHARED) && rd_sharers[src_q]);
  assert_write_reply_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_REPLY) && (kind_q == MSG_WR_MISS) |->
      (rd_state == BLK_EXCL) && (rd_sharers == src_oh));
  assert_fetch_from_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_FETCH) |-> rd_state == BLK_EXCL);
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [PW-1:0]     in_proc,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_kind,
  output logic [PW-1:0]     out_proc,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] blk_addr;
  blk_state_e        rd_state, wr_state;
  logic [NPROC-1:0]  rd_sharers, wr_sharers, pend_vec;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [PW-1:0]     pend_idx, owner_idx;
  logic              dir_we, mem_we;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dir_table #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst_n(rst_int_n), .addr(blk_addr),
    .rd_state(rd_state), .rd_sharers(rd_sharers), .rd_data(rd_data),
    .dir_we(dir_we), .wr_state(wr_state), .wr_sharers(wr_sharers),
    .mem_we(mem_we), .wr_data(wr_data)
  );

  dir_pick #(.N(NPROC)) u_pend_pick  (.vec(pend_vec),   .idx(pend_idx));
  dir_pick #(.N(NPROC)) u_owner_pick (.vec(rd_sharers), .idx(owner_idx));

  dir_engine #(.NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_proc(in_proc), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_proc(out_proc), .out_addr(out_addr), .out_data(out_data),
    .addr_q(blk_addr), .rd_state(rd_state), .rd_sharers(rd_sharers),
    .rd_data(rd_data), .pend_q(pend_vec), .pend_idx(pend_idx),
    .owner_idx(owner_idx), .dir_we(dir_we), .wr_state(wr_state),
    .wr_sharers(wr_sharers), .mem_we(mem_we), .wr_data(wr_data)
  );
endmodule

// File: tb/test_dir_home_ctrl.sv
`timescale 1ns/100ps
module test_dir_home_ctrl;
  // kind codes per R2
  localparam logic [2:0] K_RM = 3'd0, K_WM = 3'd1, K_INV = 3'd2, K_FET = 3'd3,
                         K_FINV = 3'd4, K_DATA = 3'd5, K_WB = 3'd6;
  localparam int ST_U = 0, ST_S = 1, ST_E = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [2:0] in_kind = '0, out_kind;
  logic [1:0] in_proc = '0, out_proc;
  logic [3:0] in_addr = '0, out_addr;
  logic [15:0] in_data = '0, out_data;

  int checks = 0, fails = 0;
  logic stall_en = 1'b0;
  logic [3:0] stall_cnt = '0;

  typedef struct {
    logic [2:0] k; logic [1:0] p; logic [3:0] a; logic [15:0] d; string tag;
  } exp_t;
  exp_t q[$];

  // reference model
  int          m_state [16];
  logic [3:0]  m_share [16];
  logic [15:0] m_mem   [16];

  always #2.5 clk = ~clk;

  dir_home_ctrl i_dir_home_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_proc(in_proc), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_proc(out_proc), .out_addr(out_addr), .out_data(out_data)
  );

  always @(posedge clk) begin
    stall_cnt <= stall_cnt + 4'd1;
    out_ready <= stall_en ? (stall_cnt[1] ^ stall_cnt[3]) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R8/R10 unexpected message got kind=%0d proc=%0d addr=%0d data=%h expected none",
                 out_kind, out_proc, out_addr, out_data);
      end else begin
        e = q.pop_front();
        if (out_kind !== e.k || out_proc !== e.p || out_addr !== e.a || out_data !== e.d) begin
          fails++;
          $display("FAIL %s (R2 fields) got kind=%0d proc=%0d addr=%0d data=%h expected kind=%0d proc=%0d addr=%0d data=%h",
                   e.tag, out_kind, out_proc, out_addr, out_data, e.k, e.p, e.a, e.d);
        end
      end
    end
  end

  task automatic push(input logic [2:0] k, input int p, input int a, input logic [15:0] d, input string tag);
    exp_t e;
    e.k = k; e.p = 2'(p); e.a = 4'(a); e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic [2:0] k, input int p, input int a, input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_proc = 2'(p); in_addr = 4'(a); in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int owner_of(input int a);
    for (int i = 0; i < 4; i++) if (m_share[a][i]) return i;
    return 0;
  endfunction

  task automatic do_rd(input int p, input int a, input logic [15:0] owner_val);
    int o;
    if (m_state[a] == ST_E) begin
      o = owner_of(a);
      push(K_FET, o, a, 16'h0, "R6 fetch");
      m_mem[a] = owner_val;
      push(K_DATA, p, a, owner_val, "R6 reply");
      m_share[a] = 4'(1 << o) | 4'(1 << p);
      m_state[a] = ST_S;
      send(K_RM, p, a, 16'h0);
      send(K_WB, o, a, owner_val);
    end else begin
      push(K_DATA, p, a, m_mem[a], "R1/R3 reply");
      m_share[a] = ((m_state[a] == ST_U) ? 4'h0 : m_share[a]) | 4'(1 << p);
      m_state[a] = ST_S;
      send(K_RM, p, a, 16'h0);
    end
  endtask

  task automatic do_wr(input int p, input int a, input logic [15:0] owner_val);
    int o;
    if (m_state[a] == ST_E) begin
      o = owner_of(a);
      push(K_FINV, o, a, 16'h0, "R7 fetch-inv");
      m_mem[a] = owner_val;
      push(K_DATA, p, a, owner_val, "R7 reply");
      m_share[a] = 4'(1 << p);
      m_state[a] = ST_E;
      send(K_WM, p, a, 16'h0);
      send(K_WB, o, a, owner_val);
    end else begin
      if (m_state[a] == ST_S)
        for (int i = 0; i < 4; i++)
          if (m_share[a][i] && i != p) push(K_INV, i, a, 16'h0, "R5 invalidate");
      push(K_DATA, p, a, m_mem[a], (m_state[a] == ST_S) ? "R5 reply" : "R4 reply");
      m_share[a] = 4'(1 << p);
      m_state[a] = ST_E;
      send(K_WM, p, a, 16'h0);
    end
  endtask

  task automatic do_wb(input int p, input int a, input logic [15:0] d);
    if (m_state[a] == ST_E && m_share[a][p]) begin
      m_mem[a] = d; m_state[a] = ST_U; m_share[a] = 4'h0;
    end
    send(K_WB, p, a, d);
    repeat (6) @(negedge clk);
  endtask

  task automatic settle;
    for (int i = 0; i < 400 && q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, %0d messages outstanding", q.size());
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int b = 0; b < 16; b++) begin m_state[b] = ST_U; m_share[b] = 4'h0; m_mem[b] = 16'h0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 got in_ready=%b out_valid=%b expected 1 0", in_ready, out_valid);
    end

    do_rd(0, 1, 16'h0);           // R3 uncached read, R1 zero data
    do_rd(2, 1, 16'h0);           // R3 second sharer
    stall_en = 1'b1;
    do_wr(1, 1, 16'h0);           // R5 invalidate P0, P2 in order under backpressure
    settle();
    do_rd(3, 1, 16'h1234);        // R6 fetch from owner P1
    do_wr(3, 1, 16'h0);           // R5 upgrade from sharer: invalidate P1 only
    do_wr(0, 1, 16'hBEEF);        // R7 fetch-invalidate to P3
    settle();
    stall_en = 1'b0;
    do_wb(2, 1, 16'h5555);        // R9 non-owner write-back ignored
    send(K_INV, 1, 1, 16'h7777);  // R9 stray incoming kinds ignored
    send(K_DATA, 3, 1, 16'h8888);
    repeat (6) @(negedge clk);
    do_wb(0, 1, 16'hC0DE);        // R8 owner write-back, no message
    do_rd(1, 1, 16'h0);           // R8 data visible, block was uncached
    do_wr(2, 5, 16'h0);           // R4 uncached write miss
    do_wb(1, 5, 16'hAAAA);        // R9 non-owner of exclusive block
    do_rd(0, 5, 16'h4321);        // R6 shows P2 still owner, memory refreshed
    do_rd(3, 9, 16'h0);           // R3 untouched block still zero (R1)
    settle();

    // R10: idle again with nothing left pending
    checks++;
    if (q.size() != 0 || in_ready !== 1'b1 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 got pending=%0d in_ready=%b out_valid=%b expected 0 1 0",
               q.size(), in_ready, out_valid);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule